// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block holds the single reservation that a processor core uses for load-reserve / store-conditional atomic sequences. A load-reserve records that a reservation is held and which aligned granule of memory it covers. A later store-conditional asks whether the reservation is still held. If it is, the store-conditional succeeds and its memory write is enabled. In every case the store-conditional ends the reservation.

Only write transactions snooped from other bus masters can cancel a held reservation, and only when they land inside the reserved granule. Plain stores from the local core pass straight through to memory and leave the reservation alone. A store-conditional does not compare its own address with the reserved one: holding a reservation is the only condition for success.

The outcome goes back to the core as a one-bit success flag, one cycle after the store-conditional. The memory write enable is produced in the same cycle as the request. The granule size is a parameter, 32 bytes by default.

Top module: `resv_monitor`

## Requirements
- R1: A load-reserve (req_valid with req_op = 2'b01) sets the reservation. It records only the address bits at and above log2(GRANULE_BYTES), so the low offset bits have no effect on later granule matching.
- R2: A store-conditional (req_op = 2'b10) ends the reservation whether it succeeds or fails, so a second store-conditional with no load-reserve in between fails.
- R3: A snooped transaction with snoop_valid and snoop_write high cancels a held reservation when its address lies in the reserved granule. A snooped read, or a write to any other granule, leaves the reservation held.
- R4: A plain local store (req_op = 2'b11) never cancels the reservation, even at the reserved address, and it raises mem_we in its own cycle.
- R5: A store-conditional succeeds whenever a reservation is held, whatever its address.
- R6: resp_valid is high for exactly the one cycle after each store-conditional, with resp_success giving the outcome. mem_we is high in the request cycle of a store-conditional only when it succeeds.
- R7: A store-conditional with no reservation held fails and keeps mem_we low.
- R8: A load-reserve while a reservation is held replaces the recorded granule and keeps the reservation held. Snoops to the old granule no longer cancel it.
- R9: When a cancelling snoop and a store-conditional arrive in the same cycle, the snoop wins: the store-conditional fails and mem_we stays low.
- R10: A load-reserve in the same cycle as a snooped write to its granule still leaves a reservation held afterwards.
- R11: A synchronous active-high reset clears the reservation and the response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_op | input | 2 | 01 load-reserve, 10 store-conditional, 11 plain store, 00 none |
| req_addr | input | ADDR_W | Byte address of the core request |
| snoop_valid | input | 1 | Snooped bus transaction valid |
| snoop_write | input | 1 | Snooped transaction is a write |
| snoop_addr | input | ADDR_W | Byte address of the snooped transaction |
| mem_we | output | 1 | Memory write enable for plain stores and successful store-conditionals |
| resp_valid | output | 1 | Store-conditional outcome valid |
| resp_success | output | 1 | Store-conditional succeeded |

## Verification
A wrong reservation flag or a wrong granule tag stays hidden until the next store-conditional. At that point it shows in two places: mem_we in the same cycle, and resp_success one cycle later. A flag that is wrongly held lets a second store-conditional succeed. A flag that is wrongly dropped makes a legal one fail. A wrong tag shows up as a snoop that cancels when it should not, or misses when it should. For this reason the bench sweeps every snoop address against several reserved addresses and follows each case with a store-conditional.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_LRSV  = 2'b01,
        OP_SCOND = 2'b10,
        OP_STORE = 2'b11
    } resv_op_e;
endpackage

// File: rtl/resv_granule_match.sv
module resv_granule_match #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    localparam int TAG_W = ADDR_W - OFF_W
) (
    input  logic              armed,
    input  logic [TAG_W-1:0]  tag,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [TAG_W-1:0] addr_tag;

    always_comb begin
        addr_tag = addr[ADDR_W-1:OFF_W];
        hit      = armed && (addr_tag == tag);
    end
endmodule

// File: rtl/resv_state.sv
module resv_state #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    localparam int TAG_W = ADDR_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lr_req,
    input  logic             sc_req,
    input  logic [TAG_W-1:0] lr_tag,
    input  logic             kill,
    output logic             held,
    output logic [TAG_W-1:0] tag,
    output logic             sc_pass,
    output logic             resp_valid,
    output logic             resp_success
);
    typedef struct packed {
        logic             held;
        logic [TAG_W-1:0] tag;
        logic             resp_valid;
        logic             resp_success;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        sc_pass         = sc_req && st_q.held && !kill;
        st_d.resp_valid = sc_req;
        st_d.resp_success = sc_pass;
        if (kill) begin
            st_d.held = 1'b0;
        end
        if (sc_req) begin
            st_d.held = 1'b0;
        end
        if (lr_req) begin
            st_d.held = 1'b1;
            st_d.tag  = lr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held         = st_q.held;
    assign tag          = st_q.tag;
    assign resp_valid   = st_q.resp_valid;
    assign resp_success = st_q.resp_success;
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int ADDR_W        = 32,
    parameter int GRANULE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              snoop_valid,
    input  logic              snoop_write,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              mem_we,
    output logic              resp_valid,
    output logic              resp_success
);
    import resv_pkg::*;

    localparam int OFF_W = $clog2(GRANULE_BYTES);
    localparam int TAG_W = ADDR_W - OFF_W;

    resv_op_e          op;
    logic              lr_req, sc_req, st_req;
    logic              held;
    logic [TAG_W-1:0]  tag;
    logic              snoop_hit;
    logic              sc_pass;

    always_comb begin
        op     = resv_op_e'(req_op);
        lr_req = req_valid && (op == OP_LRSV);
        sc_req = req_valid && (op == OP_SCOND);
        st_req = req_valid && (op == OP_STORE);
    end

    resv_granule_match #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_snoop_match (
        .armed (held && snoop_valid && snoop_write),
        .tag   (tag),
        .addr  (snoop_addr),
        .hit   (snoop_hit)
    );

    resv_state #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_state (
        .clk          (clk),
        .rst          (rst),
        .lr_req       (lr_req),
        .sc_req       (sc_req),
        .lr_tag       (req_addr[ADDR_W-1:OFF_W]),
        .kill         (snoop_hit),
        .held         (held),
        .tag          (tag),
        .sc_pass      (sc_pass),
        .resp_valid   (resp_valid),
        .resp_success (resp_success)
    );

    assign mem_we = st_req || sc_pass;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 27
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              snoop_valid,
    input logic              snoop_write,
    input logic              mem_we,
    input logic              resp_valid,
    input logic              resp_success,
    input logic              held,
    input logic [TAG_W-1:0]  tag,
    input logic              snoop_hit
);
    localparam int OFF_W = ADDR_W - TAG_W;

    p_lr_sets_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b01) |=> (held && tag == $past(req_addr[ADDR_W-1:OFF_W])));

    p_sc_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b10) |=> !held);

    p_store_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b11 && held && !snoop_valid) |=> held);

    p_store_we_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b11) |-> mem_we);

    p_resp_after_sc_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b10) |=> resp_valid);

    p_resp_only_sc_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op != 2'b10) |=> !resp_valid);

    p_no_resv_fail_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b10 && !held) |-> (!mem_we ##1 !resp_success));

    p_snoop_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'b10 && snoop_hit) |-> (!mem_we ##1 !resp_success));

    p_read_snoop_r3: assert property (@(posedge clk) disable iff (rst)
        (held && !snoop_write && !req_valid) |=> held);

    p_reset_r11: assert property (@(posedge clk)
        rst |=> (!held && !resp_valid));
endmodule

bind resv_monitor resv_monitor_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .snoop_valid  (snoop_valid),
    .snoop_write  (snoop_write),
    .mem_we       (mem_we),
    .resp_valid   (resp_valid),
    .resp_success (resp_success),
    .held         (held),
    .tag          (tag),
    .snoop_hit    (snoop_hit)
);

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int GB = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic          snoop_valid = 1'b0;
    logic          snoop_write = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          mem_we, resp_valid, resp_success;

    int checks = 0;
    int errors = 0;
    logic we_obs, rv_obs, rs_obs;

    resv_monitor #(.ADDR_W(AW), .GRANULE_BYTES(GB)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .snoop_valid(snoop_valid), .snoop_write(snoop_write),
        .snoop_addr(snoop_addr), .mem_we(mem_we), .resp_valid(resp_valid),
        .resp_success(resp_success)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Called at a falling edge; applies one cycle of stimulus.
    task automatic step(input logic v, input logic [1:0] op, input logic [AW-1:0] a,
                        input logic sv, input logic sw, input logic [AW-1:0] sa);
        req_valid = v; req_op = op; req_addr = a;
        snoop_valid = sv; snoop_write = sw; snoop_addr = sa;
        #1 we_obs = mem_we;
        @(negedge clk);
        rv_obs = resp_valid;
        rs_obs = resp_success;
        req_valid = 1'b0; req_op = 2'b00; snoop_valid = 1'b0; snoop_write = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, 2'b00, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic sc(input logic [AW-1:0] a, input logic exp, input string req);
        step(1'b1, 2'b10, a, 1'b0, 1'b0, '0);
        check(req, we_obs, exp);
        check(req, rv_obs, 1'b1);
        check(req, rs_obs, exp);
    endtask

    task automatic lr(input logic [AW-1:0] a);
        step(1'b1, 2'b01, a, 1'b0, 1'b0, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] lr_set [4];
        lr_set[0] = 8'h00; lr_set[1] = 8'h25; lr_set[2] = 8'hFF; lr_set[3] = 8'h80;

        repeat (3) @(negedge clk);
        check("R11 reset resp_valid", resp_valid, 1'b0);
        check("R11 reset resp_success", resp_success, 1'b0);
        rst = 1'b0;
        // R7/R11: no reservation after reset
        sc(8'h10, 1'b0, "R7 sc after reset");

        // R2: second SC fails; R5 SC at unrelated address succeeds
        lr(8'h40);
        sc(8'hC3, 1'b1, "R5 sc other address");
        sc(8'h40, 1'b0, "R2 second sc fails");

        // R6: resp_valid drops after the response cycle
        idle();
        check("R6 resp one cycle", rv_obs, 1'b0);

        // R4: local store at reserved address
        lr(8'h40);
        step(1'b1, 2'b11, 8'h40, 1'b0, 1'b0, '0);
        check("R4 store we", we_obs, 1'b1);
        check("R4 store no resp", rv_obs, 1'b0);
        sc(8'h40, 1'b1, "R4 store keeps reservation");

        // R3/R1: sweep every snoop write address against several reservations
        foreach (lr_set[i]) begin
            for (int s = 0; s < 256; s++) begin
                logic exp_ok;
                exp_ok = ((s / GB) != (int'(lr_set[i]) / GB));
                lr(lr_set[i]);
                step(1'b0, 2'b00, '0, 1'b1, 1'b1, AW'(s));
                sc(lr_set[i] ^ 8'h5A, exp_ok, "R3 R1 snoop write sweep");
            end
        end

        // R3: snoop reads never cancel
        for (int s = 0; s < 256; s++) begin
            lr(8'h25);
            step(1'b0, 2'b00, '0, 1'b1, 1'b0, AW'(s));
            sc(8'h25, 1'b1, "R3 snoop read sweep");
        end

        // R8: replacement moves the granule
        lr(8'h10);
        lr(8'h90);
        step(1'b0, 2'b00, '0, 1'b1, 1'b1, 8'h13);
        sc(8'h00, 1'b1, "R8 old granule no longer watched");
        lr(8'h10);
        lr(8'h90);
        step(1'b0, 2'b00, '0, 1'b1, 1'b1, 8'h97);
        sc(8'h00, 1'b0, "R8 new granule watched");

        // R9: snoop and SC in the same cycle
        lr(8'h60);
        step(1'b1, 2'b10, 8'h60, 1'b1, 1'b1, 8'h61);
        check("R9 same cycle we", we_obs, 1'b0);
        check("R9 same cycle resp", rs_obs, 1'b0);
        // R9 companion: snoop elsewhere in same cycle does not cancel
        lr(8'h60);
        step(1'b1, 2'b10, 8'h60, 1'b1, 1'b1, 8'h70);
        check("R9 other granule we", we_obs, 1'b1);
        check("R9 other granule resp", rs_obs, 1'b1);

        // R10: LR with same-cycle snoop to its granule
        step(1'b1, 2'b01, 8'h30, 1'b1, 1'b1, 8'h30);
        sc(8'h30, 1'b1, "R10 lr beats snoop");

        // R11: reset mid-reservation
        lr(8'h30);
        rst = 1'b1;
        idle();
        rst = 1'b0;
        sc(8'h30, 1'b0, "R11 reset clears reservation");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule